// File: doc/BRIEF.md
# Tile Buffer Color and Depth Flusher

This block holds a 16x16 pixel tile on chip for a tile-based rasterizer. The tile has a color store and a depth store, both 32 bits per pixel. A start pulse opens a tile. The block first fills both stores with fixed clear values. It then accepts per-pixel writes from the rasterizer until it is told that rendering is done. Finally it streams the whole tile out to framebuffer space: first all colors, then all depth values, each as a write strobe with an address and a data word.

Both streams use the same mapping from a tile slot to a screen address. The slot number gives a column (low four bits) and a row (next four bits). These are added to the tile origin that was latched at start. The row is scaled by the framebuffer width, which is given in units of 64 pixels. The resulting pixel number is multiplied by four to form a byte address for 32-bit entries. A parameter removes the depth stream, so the block goes back to idle right after the color stream. The active flag covers the whole job, including the last depth write.

Top module: `tile_flusher`

## Requirements
- R1: Synchronous active-low reset puts the block in idle: `phase` reads 0, both emit strobes are low and `active` is low.
- R2: A `start` pulse in idle (phase 0) enters the clear phase (phase 1). The clear phase lasts exactly 256 cycles, then the block enters the render phase (phase 2). A `start` pulse outside idle is ignored.
- R3: In the render phase, `pix_we` writes `pix_color` and `pix_depth` into tile slot `pix_idx`. A `render_done` pulse moves the block to the color flush phase (phase 3).
- R4: The color flush emits exactly 256 entries on consecutive cycles, tile slots 0 to 255 in ascending order. The first emit comes one cycle after phase 3 is entered.
- R5: When depth flush is enabled, phase 6 follows phase 3 directly. The block emits 256 depth entries in ascending slot order, and the first depth emit comes in the cycle after the last color emit. Color and depth strobes are never high together.
- R6: Emitted data equals the stored tile contents, unchanged. Slots not written during render carry color 0xFF008000 and depth 0x00004000.
- R7: For slot i, x = i & 15 and y = (i >> 4) & 15. The emit address is 4 * ((oy + y) * (fbw * 64) + ox + x), using the origin `org_x`/`org_y` and width `fb_width` latched at start.
- R8: `active` is high from start until the last depth emit, and goes low in the cycle after that emit.
- R9: With depth flush disabled, the block returns to idle after the 256th color emit. It makes no depth emits, and `active` goes low in the cycle after the last color emit.
- R10: `pix_we` has no effect outside the render phase, whether during clear or during a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Open a new tile (accepted in idle only) |
| org_x | input | 16 | Tile origin column in pixels |
| org_y | input | 16 | Tile origin row in pixels |
| fb_width | input | 6 | Framebuffer width in units of 64 pixels |
| pix_we | input | 1 | Pixel write strobe (render phase only) |
| pix_idx | input | 8 | Tile slot of the pixel write |
| pix_color | input | 32 | Color word to store |
| pix_depth | input | 32 | Depth word to store |
| render_done | input | 1 | End of render, begins flushing |
| color_emit | output | 1 | Color write strobe |
| depth_emit | output | 1 | Depth write strobe |
| emit_addr | output | 32 | Byte address of the current emit |
| color_data | output | 32 | Color word of the current emit |
| depth_data | output | 32 | Depth word of the current emit |
| active | output | 1 | Tile job in progress |
| phase | output | 3 | Current phase code |

## Verification
The phase changes on the edge that samples `start` or `render_done`. The first color emit is due one cycle after phase 3 appears, because the store read adds one register. The depth stream follows the last color emit with no gap, and `active` falls one cycle after the last emit. The bench samples every output at the falling edge and stamps each emit and each `active` change with a cycle count. It then checks each of these offsets exactly, not within a window.

// File: rtl/tile_flusher.sv
module tile_flusher #(
  parameter int TILE_DIM = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int ORG_W = 16,
  parameter int FBW_W = 6,
  parameter int FBW_SHIFT = 6,
  parameter bit ZFLUSH_EN = 1'b1,
  parameter logic [DATA_W-1:0] CLEAR_COLOR = 32'hFF00_8000,
  parameter logic [DATA_W-1:0] CLEAR_DEPTH = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ORG_W-1:0]  org_x,
  input  logic [ORG_W-1:0]  org_y,
  input  logic [FBW_W-1:0]  fb_width,
  input  logic              pix_we,
  input  logic [7:0]        pix_idx,
  input  logic [DATA_W-1:0] pix_color,
  input  logic [DATA_W-1:0] pix_depth,
  input  logic              render_done,
  output logic              color_emit,
  output logic              depth_emit,
  output logic [ADDR_W-1:0] emit_addr,
  output logic [DATA_W-1:0] color_data,
  output logic [DATA_W-1:0] depth_data,
  output logic              active,
  output logic [2:0]        phase
);
  localparam int N  = TILE_DIM * TILE_DIM;
  localparam int IW = $clog2(N);
  localparam int XW = $clog2(TILE_DIM);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_CLEAR = 3'd1, PH_RENDER = 3'd2,
                         PH_CFLUSH = 3'd3, PH_ZFLUSH = 3'd6;

  logic [DATA_W-1:0] cmem [N];
  logic [DATA_W-1:0] zmem [N];
  logic [IW-1:0]     cnt, e_idx;
  logic              c_v, z_v;
  logic [ORG_W-1:0]  ox_q, oy_q;
  logic [FBW_W-1:0]  fbw_q;
  logic [DATA_W-1:0] c_rd, z_rd;
  wire               last = (cnt == IW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      e_idx <= '0;
      c_v   <= 1'b0;
      z_v   <= 1'b0;
      ox_q  <= '0;
      oy_q  <= '0;
      fbw_q <= '0;
    end else begin
      c_v   <= (phase == PH_CFLUSH);
      z_v   <= (phase == PH_ZFLUSH);
      e_idx <= cnt;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_CLEAR;
          cnt   <= '0;
          ox_q  <= org_x;
          oy_q  <= org_y;
          fbw_q <= fb_width;
        end
        PH_CLEAR: begin
          cnt <= cnt + 1'b1;
          if (last) phase <= PH_RENDER;
        end
        PH_RENDER: if (render_done) begin
          phase <= PH_CFLUSH;
          cnt   <= '0;
        end
        PH_CFLUSH: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) phase <= ZFLUSH_EN ? PH_ZFLUSH : PH_IDLE;
        end
        PH_ZFLUSH: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (phase == PH_CLEAR) begin
      cmem[cnt] <= CLEAR_COLOR;
      zmem[cnt] <= CLEAR_DEPTH;
    end else if (phase == PH_RENDER && pix_we) begin
      cmem[pix_idx[IW-1:0]] <= pix_color;
      zmem[pix_idx[IW-1:0]] <= pix_depth;
    end
    c_rd <= cmem[cnt];
    z_rd <= zmem[cnt];
  end

  wire [ADDR_W-1:0] ex     = ADDR_W'(e_idx[XW-1:0]);
  wire [ADDR_W-1:0] ey     = ADDR_W'(e_idx[IW-1:XW]);
  wire [ADDR_W-1:0] stride = ADDR_W'(fbw_q) << FBW_SHIFT;
  wire [ADDR_W-1:0] sidx   = (ADDR_W'(oy_q) + ey) * stride + ADDR_W'(ox_q) + ex;

  assign emit_addr  = sidx << 2;
  assign color_emit = c_v;
  assign depth_emit = z_v;
  assign color_data = c_rd;
  assign depth_data = z_rd;
  assign active     = (phase != PH_IDLE) || c_v || z_v;
endmodule

module tile_flusher_chk #(
  parameter bit ZEN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] phase,
  input logic       color_emit,
  input logic       depth_emit,
  input logic       active
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase inside {3'd2, 3'd3, 3'd6}) |=> phase != 3'd1); // R2
  AST_RENDER_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 && $past(phase) != 3'd2) |-> $past(phase) == 3'd1); // R2
  AST_ZF_AFTER_CF: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd6 && $past(phase) != 3'd6) |-> $past(phase) == 3'd3); // R5
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(color_emit && depth_emit)); // R5
  AST_EMIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (color_emit || depth_emit) |-> active); // R8
  AST_NO_DEPTH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ZEN |-> !depth_emit); // R9
endmodule

bind tile_flusher tile_flusher_chk #(.ZEN(ZFLUSH_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
  .color_emit(color_emit), .depth_emit(depth_emit), .active(active)
);

// File: tb/test_tile_flusher.sv
`timescale 1ns/1ps
module test_tile_flusher;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, pix_we, render_done;
  logic [15:0] org_x, org_y;
  logic [5:0] fb_width;
  logic [7:0] pix_idx;
  logic [31:0] pix_color, pix_depth;
  logic c_emit, z_emit, act;
  logic [31:0] e_addr, c_data, z_data;
  logic [2:0] ph;
  logic n_c_emit, n_z_emit, n_act;
  logic [31:0] n_addr, n_cdata, n_zdata;
  logic [2:0] n_ph;

  tile_flusher i_tile_flusher (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .fb_width(fb_width), .pix_we(pix_we), .pix_idx(pix_idx), .pix_color(pix_color),
    .pix_depth(pix_depth), .render_done(render_done), .color_emit(c_emit),
    .depth_emit(z_emit), .emit_addr(e_addr), .color_data(c_data),
    .depth_data(z_data), .active(act), .phase(ph));

  tile_flusher #(.ZFLUSH_EN(1'b0)) i_tile_flusher_nz (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .fb_width(fb_width), .pix_we(pix_we), .pix_idx(pix_idx), .pix_color(pix_color),
    .pix_depth(pix_depth), .render_done(render_done), .color_emit(n_c_emit),
    .depth_emit(n_z_emit), .emit_addr(n_addr), .color_data(n_cdata),
    .depth_data(n_zdata), .active(n_act), .phase(n_ph));

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] exp_c [256];
  logic [31:0] exp_z [256];
  logic [31:0] ca [256], cd [256], za [256], zd [256];
  int cc, zc, nc, nzc, clr_n;
  int c_first, c_last, z_first, z_last, fall, n_last, n_fall, cf_seen;
  logic p_act, p_nact;
  int t_ox, t_oy, t_fbw;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act_v, input longint exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (ph == 3'd1) clr_n++;
    if (ph == 3'd3 && cf_seen < 0) cf_seen = cyc;
    if (c_emit) begin
      if (cc < 256) begin ca[cc] = e_addr; cd[cc] = c_data; end
      if (cc == 0) c_first = cyc;
      c_last = cyc; cc++;
    end
    if (z_emit) begin
      if (zc < 256) begin za[zc] = e_addr; zd[zc] = z_data; end
      if (zc == 0) z_first = cyc;
      z_last = cyc; zc++;
    end
    if (n_c_emit) begin nc++; n_last = cyc; end
    if (n_z_emit) nzc++;
    if (p_act && !act && fall < 0) fall = cyc;
    if (p_nact && !n_act && n_fall < 0) n_fall = cyc;
    p_act = act;
    p_nact = n_act;
  end

  function automatic logic [31:0] addr_of(input int i);
    return 32'((((t_oy + ((i >> 4) & 15)) * (t_fbw * 64)) + t_ox + (i & 15)) * 4);
  endfunction

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; pix_we = 1'b0; render_done = 1'b0;
    org_x = '0; org_y = '0; fb_width = 6'd1; pix_idx = '0; pix_color = '0; pix_depth = '0;
    idle_cycles(3);
    chk(ph == 3'd0, "R1", "phase in reset", ph, 0);
    chk(!c_emit && !z_emit && !act, "R1", "strobes/active in reset", {c_emit, z_emit, act}, 0);
    rst_n = 1'b1;
    idle_cycles(2);
    chk(ph == 3'd0 && !act, "R1", "idle after reset", {ph, act}, 0);
  endtask

  task automatic open_tile(input int ox, input int oy, input int fbw);
    t_ox = ox; t_oy = oy; t_fbw = fbw;
    for (int i = 0; i < 256; i++) begin exp_c[i] = 32'hFF00_8000; exp_z[i] = 32'h0000_4000; end
    cc = 0; zc = 0; nc = 0; nzc = 0; clr_n = 0; cf_seen = -1;
    c_first = -1; c_last = -1; z_first = -1; z_last = -1; fall = -1; n_last = -1; n_fall = -1;
    org_x = 16'(ox); org_y = 16'(oy); fb_width = 6'(fbw);
    start = 1'b1; @(negedge clk); start = 1'b0;
    org_x = 16'hFFFF; org_y = 16'hFFFF; fb_width = 6'd5;
    idle_cycles(10);
    // R10: write during clear is dropped; R2: start during clear is ignored
    pix_we = 1'b1; pix_idx = 8'd0; pix_color = 32'h1111_1111; pix_depth = 32'hDEAD_0000;
    start = 1'b1;
    @(negedge clk);
    pix_we = 1'b0; start = 1'b0;
    for (int k = 0; k < 400 && ph != 3'd2; k++) @(negedge clk);
    chk(ph == 3'd2, "R2", "render phase reached", ph, 2);
    chk(clr_n == 256, "R2", "clear cycles", clr_n, 256);
  endtask

  task automatic wr(input int idx, input logic [31:0] c, input logic [31:0] z);
    pix_we = 1'b1; pix_idx = 8'(idx); pix_color = c; pix_depth = z;
    @(negedge clk);
    pix_we = 1'b0;
    exp_c[idx] = c; exp_z[idx] = z;
  endtask

  task automatic close_tile(input string tag);
    int bca, bcd, bza, bzd, first_bad;
    render_done = 1'b1; @(negedge clk); render_done = 1'b0;
    // R10: write during color flush must not reach the depth store
    pix_we = 1'b1; pix_idx = 8'd200; pix_color = 32'h2222_2222; pix_depth = 32'h0000_1234;
    @(negedge clk); pix_we = 1'b0;
    for (int k = 0; k < 800 && (act || n_act); k++) @(negedge clk);
    idle_cycles(3);
    bca = 0; bcd = 0; bza = 0; bzd = 0; first_bad = -1;
    for (int i = 0; i < 256; i++) begin
      if (ca[i] !== addr_of(i)) begin bca++; if (first_bad < 0) first_bad = i; end
      if (cd[i] !== exp_c[i]) bcd++;
      if (za[i] !== addr_of(i)) bza++;
      if (zd[i] !== exp_z[i]) bzd++;
    end
    $display("%s: first address mismatch slot %0d", tag, first_bad);
    chk(cf_seen >= 0 && c_first == cf_seen + 1, "R4", "first color emit cycle", c_first, cf_seen + 1);
    chk(cc == 256, "R4", "color emit count", cc, 256);
    chk(c_last == c_first + 255, "R4", "color stream gapless", c_last - c_first, 255);
    chk(bca == 0, "R7", "color address mismatches", bca, 0);
    chk(bcd == 0, "R6", "color data mismatches", bcd, 0);
    chk(zc == 256, "R5", "depth emit count", zc, 256);
    chk(z_first == c_last + 1, "R5", "depth follows color", z_first, c_last + 1);
    chk(bza == 0, "R7", "depth address mismatches", bza, 0);
    chk(bzd == 0, "R6", "depth data mismatches", bzd, 0);
    chk(zd[200] === exp_z[200], "R10", "depth slot 200 after flush-time write", zd[200], exp_z[200]);
    chk(fall == z_last + 1, "R8", "active fall cycle", fall, z_last + 1);
    chk(nc == 256 && nzc == 0, "R9", "no-depth variant emits", {nc, nzc}, 256 << 32);
    chk(n_fall == n_last + 1, "R9", "no-depth variant active fall", n_fall, n_last + 1);
    chk(ph == 3'd0 && n_ph == 3'd0, "R9", "both back in idle", {ph, n_ph}, 0);
  endtask

  task automatic t_blank_tile;
    open_tile(0, 0, 1);
    close_tile("blank");
  endtask

  task automatic t_rendered_tile;
    open_tile(32, 16, 2);
    wr(0, 32'hA0A0_0001, 32'h8000_0001);   // R3
    wr(15, 32'hA0A0_000F, 32'hFFFF_FFFF);
    wr(16, 32'hA0A0_0010, 32'h0102_0304);
    wr(137, 32'hA0A0_0089, 32'h00FF_FF00);
    wr(255, 32'hA0A0_00FF, 32'h7654_3210);
    wr(15, 32'hB0B0_000F, 32'h0000_0000);
    close_tile("rendered");
  endtask

  task automatic t_wide_tile;
    open_tile(100, 7, 63);
    for (int i = 0; i < 256; i += 9) wr(i, 32'(i * 32'h0101_0101), 32'(~(i * 32'h0001_0003)));
    close_tile("wide");
  endtask

  bit finished = 1'b0;
  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    p_act = 1'b0; p_nact = 1'b0;
    t_reset;
    t_blank_tile;
    t_rendered_tile;
    t_wide_tile;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule